// File: doc/BRIEF.md
# Multi-Line Transmit Silo Controller

This block is the transmit half of an eight-line asynchronous serial multiplexer. Every line owns a 32-character transmit queue (a "silo"). Software sees only two 16-bit words: a control/status word and an indirect data word. The indirect data word is steered by a register-select code and a line number held in the control/status word. Software picks a line, writes characters into that line's queue through the low byte of the indirect word, reads the queue fill level back, and sets the per-line control byte. The control byte gates output, and writing it with the flush bit set empties the queue at once.

Each line presents its oldest character to its serializer over a valid/ready handshake. A line that runs dry, whether by sending its last character or by a flush, posts a drain event. Events are reported one at a time through the flag bit of the control/status word, together with the line number. Each read of that word while the flag is up acknowledges the line it reports. A round-robin pick chooses the next pending line. An interrupt output follows the flag, gated by the interrupt enable.

A master-clear bit starts a sequence that wipes every queue, every control byte and every pending event, one line per cycle. The bit reads back as 1 until the sequence has finished.

Top module: `txsilo_mux`

## Requirements
- R1: After reset the control/status word reads 0x0000, `tx_irq` is low, every `line_valid` bit is low and every queue count reads 0.
- R2: In the control/status word, bit 14 (transmit interrupt enable), bit 6 (receive interrupt enable) and bits 4:0 (bits 4:3 the indirect register code, bits 2:0 the line) are written and read back. Bits 13 and 7 always read 0.
- R3: With register code 0, a write with byte lane 0 enabled appends bits 7:0 of the write data to the selected line's queue. A read returns the queue count in the low byte. A write to a full queue (32 entries) is dropped, and the count stays 32.
- R4: A line with a non-empty queue and control bit 0 (transmit enable) set drives `line_valid` high. It presents its characters on its byte of `line_data` in write order, one per cycle in which `line_ready` is also high.
- R5: While transmit enable is 0, the line's `line_valid` is low and its queue contents and count are kept. Setting the bit again resumes output where it stopped.
- R6: Register code 1, byte lane 0, is the line control byte. A write with bit 4 set empties the queue and posts a drain event for that line, even if the queue was already empty. Bit 4 is not stored and reads 0.
- R7: When a line's last character leaves with no write to the same queue in that cycle, a drain event for that line is posted. The control/status word then shows bit 15 set and the line number in bits 10:8.
- R8: Each read of the control/status word while bit 15 is set acknowledges the reported line. The next pending line is the first one at or after (last acknowledged line + 1), wrapping modulo 8. The search starts at line 0 after reset.
- R9: `tx_irq` is high exactly when bit 15 and bit 14 of the control/status word are both set.
- R10: A write of bit 5 of the control/status word clears all queues, control bytes, modem status bytes, pending events and the control/status fields. Bit 5 reads 1 for 8 cycles, counted from the cycle after the write. All bus writes during those 8 cycles are ignored.
- R11: The high byte of register code 1 is a per-line modem status byte that is stored and read back. Register codes 2 and 3 read 0x0000, and writes to them change no queue, control byte or event.
- R12: A write to one line's queue leaves every other line's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status word, 1 = indirect data word |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| line_valid | output | 8 | Per-line character available |
| line_data | output | 64 | Per-line character, line n in bits 8n+7:8n |
| line_ready | input | 8 | Per-line serializer accepts the character |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench fills one queue past 32 entries: a design without the full guard would wrap its pointers and report a small count. It pauses a line in mid-stream and expects exactly one character gone, which catches an enable that is sampled late or a pause that drops the queue. It raises events on lines 1, 3 and 6 while the search pointer sits at 6, then on 2 and 7 with the pointer at 4. A fixed-priority picker would report them in numeric order, and a design that never acknowledged would repeat one line. The master-clear bit is read back cycle by cycle to pin down the 8-cycle length, and writes made during the clear must leave no trace.

// File: rtl/txsilo_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the transmit silo controller.
// Assumes the line-number field is three bits wide, as the register layout requires.
package txsilo_pkg;
    localparam int LINE_W    = 3;
    localparam int NUM_LINES = 1 << LINE_W;

    // Control/status word bit positions
    localparam int CSR_FLAG  = 15;
    localparam int CSR_TIE   = 14;
    localparam int CSR_RIE   = 6;
    localparam int CSR_CLR   = 5;

    // Line control byte bit positions
    localparam int LC_TXEN   = 0;
    localparam int LC_FLUSH  = 4;

    // Indirect register codes (control/status bits 4:3)
    typedef enum logic [1:0] {
        IR_TXQ    = 2'd0,
        IR_LCTL   = 2'd1,
        IR_DMAADR = 2'd2,
        IR_DMACNT = 2'd3
    } ind_reg_e;
endpackage

// File: rtl/txsilo_fifo.sv
`timescale 1ns/1ps
// Single-line transmit queue: a circular buffer with a fill count.
// Assumes: the caller gates pop with a non-empty queue. A push to a full queue
// is dropped here. A clear wins over a push or pop in the same cycle.
module txsilo_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    // Store the incoming character at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // A push into a full queue without a pop must leave it full, not wrap.
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/txsilo_rr_pick.sv
`timescale 1ns/1ps
// Pending drain-event store with a round-robin pick.
// Holds one pending bit per line. It reports the first pending line at or after
// the search pointer, and on acknowledge drops that line and moves the pointer
// just past it. A new event for the same line in the acknowledge cycle wins.
module txsilo_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [N-1:0]     set_vec,
    input  logic             ack,
    output logic             pend_any,
    output logic [IDX_W-1:0] pend_idx
);
    logic [N-1:0]     pending_q;
    logic [IDX_W-1:0] ptr_q;
    logic [N-1:0]     ack_mask;
    logic [IDX_W-1:0] cand;
    logic             found;

    assign pend_any = |pending_q;

    // Search from the pointer for the first pending line.
    always_comb begin
        found    = 1'b0;
        pend_idx = '0;
        cand     = '0;
        for (int i = 0; i < N; i++) begin
            cand = IDX_W'((int'(ptr_q) + i) % N);
            if (!found && pending_q[cand]) begin
                found    = 1'b1;
                pend_idx = cand;
            end
        end
        ack_mask = (ack && pend_any) ? (N'(1) << pend_idx) : '0;
    end

    // Record new events, retire the acknowledged line, advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            pending_q <= '0;
            ptr_q     <= '0;
        end else begin
            pending_q <= (pending_q & ~ack_mask) | set_vec;
            if (ack && pend_any)
                ptr_q <= (pend_idx == IDX_W'(N-1)) ? '0 : pend_idx + 1'b1;
        end
    end

    // An acknowledged line without a fresh event is gone in the next cycle.
    assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_any && !clr_all && !set_vec[pend_idx]) |=> !pending_q[$past(pend_idx)]);
endmodule

// File: rtl/txsilo_mux.sv
`timescale 1ns/1ps
// Multi-line transmit silo controller (top).
// Decodes the control/status word and the indirect data word, holds one queue
// per line, drives the per-line character handshakes, posts drain events into
// the round-robin picker and runs the one-line-per-cycle master clear.
// Assumes: one bus access per bus_sel cycle; reads take effect (acknowledge) at
// the clock edge that ends the access.
module txsilo_mux
    import txsilo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CHAR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic                        bus_addr,
    input  logic [1:0]                  bus_be,
    input  logic [15:0]                 bus_wdata,
    output logic [15:0]                 bus_rdata,
    output logic [NUM_LINES-1:0]        line_valid,
    output logic [NUM_LINES*CHAR_W-1:0] line_data,
    input  logic [NUM_LINES-1:0]        line_ready,
    output logic                        tx_irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // Control/status state
    logic              tie_q, rie_q;
    logic [4:0]        sel_q;
    logic              clr_busy;
    logic [LINE_W-1:0] clr_idx;

    // Per-line state
    logic [NUM_LINES-1:0][7:0] lctl_q;
    logic [NUM_LINES-1:0][7:0] tms_q;
    logic [CNT_W-1:0]          cnt [NUM_LINES];
    logic [NUM_LINES-1:0]      empty_vec, push_vec, pop_vec, flush_vec, fifo_clr, drain_set;

    // Decode
    logic              wr_ok, csr_wr, ind_wr, start_clr, lctl_wr_lo, tms_wr, csr_rd_ack;
    logic [LINE_W-1:0] sel_line;
    ind_reg_e          sel_reg;
    logic              pend_any;
    logic [LINE_W-1:0] pend_line;
    logic [15:0]       csr_word, ind_word;

    assign sel_line   = sel_q[LINE_W-1:0];
    assign sel_reg    = ind_reg_e'(sel_q[4:3]);
    assign wr_ok      = bus_sel && bus_we && !clr_busy;
    assign csr_wr     = wr_ok && !bus_addr;
    assign ind_wr     = wr_ok && bus_addr;
    assign start_clr  = csr_wr && bus_be[0] && bus_wdata[CSR_CLR];
    assign lctl_wr_lo = ind_wr && bus_be[0] && (sel_reg == IR_LCTL);
    assign tms_wr     = ind_wr && bus_be[1] && (sel_reg == IR_LCTL);
    assign csr_rd_ack = bus_sel && !bus_we && !bus_addr && pend_any;
    assign tx_irq     = pend_any && tie_q;

    // Per-line strobes, handshake and event detection.
    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) begin
            push_vec[l]   = ind_wr && bus_be[0] && (sel_reg == IR_TXQ) && (sel_line == LINE_W'(l));
            flush_vec[l]  = lctl_wr_lo && bus_wdata[LC_FLUSH] && (sel_line == LINE_W'(l));
            fifo_clr[l]   = flush_vec[l] || (clr_busy && (clr_idx == LINE_W'(l)));
            line_valid[l] = !empty_vec[l] && lctl_q[l][LC_TXEN] && !clr_busy;
            pop_vec[l]    = line_valid[l] && line_ready[l];
            drain_set[l]  = !clr_busy && (flush_vec[l] ||
                            (pop_vec[l] && !push_vec[l] && (cnt[l] == CNT_W'(1))));
        end
    end

    // One queue per line.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        txsilo_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (fifo_clr[l]),
            .push  (push_vec[l]),
            .din   (bus_wdata[CHAR_W-1:0]),
            .pop   (pop_vec[l]),
            .dout  (line_data[l*CHAR_W +: CHAR_W]),
            .count (cnt[l]),
            .empty (empty_vec[l])
        );

        // While paused, only a write or a clear may change the count.
        assert_paused_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!lctl_q[l][LC_TXEN] && !push_vec[l] && !fifo_clr[l]) |=> (cnt[l] == $past(cnt[l])));

        // Sending the last character must raise the transmit flag.
        assert_drain_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_vec[l] && !push_vec[l] && (cnt[l] == CNT_W'(1)) && !clr_busy) |=> pend_any);
    end

    // Drain-event store and round-robin pick.
    txsilo_rr_pick #(.N(NUM_LINES), .IDX_W(LINE_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_busy || start_clr),
        .set_vec  (drain_set),
        .ack      (csr_rd_ack),
        .pend_any (pend_any),
        .pend_idx (pend_line)
    );

    // Master-clear sequencer: one line per cycle, busy for NUM_LINES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_busy <= 1'b0;
            clr_idx  <= '0;
        end else if (clr_busy) begin
            if (clr_idx == LINE_W'(NUM_LINES-1))
                clr_busy <= 1'b0;
            clr_idx <= clr_idx + 1'b1;
        end else if (start_clr) begin
            clr_busy <= 1'b1;
            clr_idx  <= '0;
        end
    end

    // Control/status fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n || start_clr) begin
            tie_q <= 1'b0;
            rie_q <= 1'b0;
            sel_q <= '0;
        end else if (csr_wr) begin
            if (bus_be[1])
                tie_q <= bus_wdata[CSR_TIE];
            if (bus_be[0]) begin
                rie_q <= bus_wdata[CSR_RIE];
                sel_q <= bus_wdata[4:0];
            end
        end
    end

    // Per-line control and modem status bytes.
    always_ff @(posedge clk) begin
        for (int l = 0; l < NUM_LINES; l++) begin
            if (!rst_n || (clr_busy && (clr_idx == LINE_W'(l)))) begin
                lctl_q[l] <= '0;
                tms_q[l]  <= '0;
            end else if (sel_line == LINE_W'(l)) begin
                if (lctl_wr_lo)
                    lctl_q[l] <= bus_wdata[7:0] & ~(8'(1) << LC_FLUSH);
                if (tms_wr)
                    tms_q[l] <= bus_wdata[15:8];
            end
        end
    end

    // Read data for both words.
    always_comb begin
        csr_word            = '0;
        csr_word[CSR_FLAG]  = pend_any;
        csr_word[CSR_TIE]   = tie_q;
        csr_word[10:8]      = pend_any ? pend_line : '0;
        csr_word[CSR_RIE]   = rie_q;
        csr_word[CSR_CLR]   = clr_busy;
        csr_word[4:0]       = sel_q;
        ind_word            = '0;
        case (sel_reg)
            IR_TXQ:  ind_word[7:0] = 8'(cnt[sel_line]);
            IR_LCTL: ind_word      = {tms_q[sel_line], lctl_q[sel_line]};
            default: ind_word      = '0;
        endcase
        bus_rdata = bus_addr ? ind_word : csr_word;
    end

    // Once a clear is under way, the interrupt must stay low.
    assert_quiet_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> !tx_irq);

    // Without the enable, no interrupt may be raised.
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tie_q |-> !tx_irq);
endmodule

// File: tb/txsilo_mux_tb.sv
`timescale 1ns/1ps
// Directed bench for the transmit silo controller; one task per scenario.
module txsilo_mux_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  line_valid;
    logic [63:0] line_data;
    logic [7:0]  line_ready = '0;
    logic        tx_irq;
    int          n_chk = 0, n_bad = 0;
    logic        tie_b = 1'b0;

    txsilo_mux dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .line_valid(line_valid), .line_data(line_data),
        .line_ready(line_ready), .tx_irq(tx_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 2'b00;
    endtask

    task automatic bus_rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pick(input int rg, input int ln);
        bus_wr(1'b0, 2'b11, 16'((int'(tie_b) << 14) | (rg << 3) | ln));
    endtask

    task automatic rd_ind(input int rg, input int ln, output logic [15:0] d);
        pick(rg, ln);
        bus_rd(1'b1, d);
    endtask

    task automatic flush_line(input int ln);
        pick(1, ln);
        bus_wr(1'b1, 2'b01, 16'h0010);
    endtask

    task automatic expect_event(input string req, input int ln);
        logic [15:0] r;
        bus_rd(1'b0, r);
        chk(req, "flag", int'(r[15]), 1);
        chk(req, "event line", int'(r[10:8]), ln);
    endtask

    task automatic t_reset_state;
        logic [15:0] r;
        bus_rd(1'b0, r);
        chk("R1", "csr after reset", int'(r), 0);
        chk("R1", "irq after reset", int'(tx_irq), 0);
        chk("R1", "valid after reset", int'(line_valid), 0);
        rd_ind(0, 7, r);
        chk("R1", "count after reset", int'(r), 0);
    endtask

    task automatic t_csr_fields;
        logic [15:0] r;
        bus_wr(1'b0, 2'b11, 16'h60D5);   // bits 14,13,7,6 and select 2:5
        bus_rd(1'b0, r);
        chk("R2", "csr readback", int'(r), 16'h4055);
        bus_wr(1'b0, 2'b11, 16'h0000);
        bus_rd(1'b0, r);
        chk("R2", "csr cleared", int'(r), 0);
    endtask

    task automatic t_push_full;
        logic [15:0] r;
        pick(0, 2);
        for (int i = 0; i < 5; i++) bus_wr(1'b1, 2'b01, 16'(8'h30 + i));
        bus_rd(1'b1, r);
        chk("R3", "count after 5 writes", int'(r), 5);
        rd_ind(0, 4, r);
        chk("R12", "other line count", int'(r), 0);
        pick(0, 2);
        for (int i = 0; i < 30; i++) bus_wr(1'b1, 2'b01, 16'(i));
        bus_rd(1'b1, r);
        chk("R3", "count when full", int'(r), 32);
        flush_line(2);
        rd_ind(0, 2, r);
        chk("R6", "count after flush", int'(r), 0);
        expect_event("R6", 2);
        bus_rd(1'b0, r);
        chk("R8", "flag after ack", int'(r[15]), 0);
        rd_ind(1, 2, r);
        chk("R6", "flush bit not stored", int'(r), 0);
    endtask

    task automatic t_order;
        logic [7:0] got [3];
        int k = 0;
        pick(0, 3);
        bus_wr(1'b1, 2'b01, 16'h0041);
        bus_wr(1'b1, 2'b01, 16'h0042);
        bus_wr(1'b1, 2'b01, 16'h0043);
        pick(1, 3);
        bus_wr(1'b1, 2'b01, 16'h0001);
        @(negedge clk);
        chk("R4", "valid when enabled", int'(line_valid[3]), 1);
        line_ready[3] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (line_valid[3] && k < 3) begin
                got[k] = line_data[31:24];
                k++;
            end
            @(negedge clk);
        end
        line_ready[3] = 1'b0;
        chk("R4", "chars sent", k, 3);
        chk("R4", "first char", int'(got[0]), 8'h41);
        chk("R4", "second char", int'(got[1]), 8'h42);
        chk("R4", "third char", int'(got[2]), 8'h43);
        expect_event("R7", 3);
    endtask

    task automatic t_pause;
        logic [15:0] r;
        line_ready[5] = 1'b1;
        pick(0, 5);
        for (int i = 0; i < 4; i++) bus_wr(1'b1, 2'b01, 16'(8'h50 + i));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R5", "valid while disabled", int'(line_valid[5]), 0);
        bus_rd(1'b1, r);
        chk("R5", "count kept while disabled", int'(r), 4);
        pick(1, 5);
        bus_wr(1'b1, 2'b01, 16'h0001);   // enable: one character leaves
        bus_wr(1'b1, 2'b01, 16'h0000);   // pause again
        rd_ind(0, 5, r);
        chk("R5", "count after brief enable", int'(r), 3);
        chk("R5", "valid after pause", int'(line_valid[5]), 0);
        bus_rd(1'b0, r);
        chk("R5", "no event while paused", int'(r[15]), 0);
        pick(1, 5);
        bus_wr(1'b1, 2'b01, 16'h0001);
        repeat (6) @(posedge clk);
        rd_ind(0, 5, r);
        chk("R5", "count after resume", int'(r), 0);
        line_ready[5] = 1'b0;
        expect_event("R7", 5);
    endtask

    task automatic t_round_robin;
        logic [15:0] r;
        flush_line(1);
        flush_line(3);
        flush_line(6);
        @(negedge clk);
        chk("R9", "irq with enable clear", int'(tx_irq), 0);
        tie_b = 1'b1;
        pick(1, 6);
        @(negedge clk);
        chk("R9", "irq with enable set", int'(tx_irq), 1);
        expect_event("R8", 6);
        expect_event("R8", 1);
        expect_event("R8", 3);
        bus_rd(1'b0, r);
        chk("R8", "flag after all acks", int'(r[15]), 0);
        chk("R9", "irq after all acks", int'(tx_irq), 0);
        flush_line(2);
        flush_line(7);
        expect_event("R8", 7);
        expect_event("R8", 2);
        tie_b = 1'b0;
        pick(0, 0);
    endtask

    task automatic t_other_regs;
        logic [15:0] r;
        pick(2, 0);
        bus_wr(1'b1, 2'b11, 16'hFFFF);
        bus_rd(1'b1, r);
        chk("R11", "code 2 reads 0", int'(r), 0);
        pick(3, 0);
        bus_wr(1'b1, 2'b11, 16'hFFFF);
        bus_rd(1'b1, r);
        chk("R11", "code 3 reads 0", int'(r), 0);
        rd_ind(0, 0, r);
        chk("R11", "count untouched", int'(r), 0);
        rd_ind(1, 0, r);
        chk("R11", "control untouched", int'(r), 0);
        bus_rd(1'b0, r);
        chk("R11", "no event", int'(r[15]), 0);
        pick(1, 0);
        bus_wr(1'b1, 2'b10, 16'hA500);
        bus_rd(1'b1, r);
        chk("R11", "modem status byte", int'(r), 16'hA500);
    endtask

    task automatic t_master_clear;
        logic [15:0] r;
        pick(0, 6);
        for (int i = 0; i < 3; i++) bus_wr(1'b1, 2'b01, 16'h0066);
        pick(1, 1);
        bus_wr(1'b1, 2'b01, 16'h002D);
        flush_line(0);
        tie_b = 1'b1;
        pick(0, 0);
        @(negedge clk);
        chk("R10", "irq before clear", int'(tx_irq), 1);
        tie_b = 1'b0;
        bus_wr(1'b0, 2'b11, 16'h0020);
        for (int i = 0; i < 8; i++) begin
            bus_rd(1'b0, r);
            chk("R10", $sformatf("busy read %0d", i), int'(r), 16'h0020);
        end
        bus_rd(1'b0, r);
        chk("R10", "done after 8 cycles", int'(r), 0);
        chk("R10", "irq after clear", int'(tx_irq), 0);
        rd_ind(0, 6, r);
        chk("R10", "queue cleared", int'(r), 0);
        rd_ind(1, 1, r);
        chk("R10", "control cleared", int'(r), 0);
        rd_ind(1, 0, r);
        chk("R10", "modem status cleared", int'(r), 0);
        bus_wr(1'b0, 2'b11, 16'h0020);
        bus_wr(1'b1, 2'b01, 16'h0077);    // push to line 0 during clear
        bus_wr(1'b0, 2'b11, 16'h4000);    // enable write during clear
        repeat (10) @(posedge clk);
        bus_rd(1'b0, r);
        chk("R10", "csr write ignored while busy", int'(r), 0);
        bus_rd(1'b1, r);
        chk("R10", "push ignored while busy", int'(r), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_csr_fields();
        t_push_full();
        t_order();
        t_pause();
        t_round_robin();
        t_other_regs();
        t_master_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule